// File: doc/BRIEF.md
# Block Protection Tuple Generator

This block sits in a byte-wide data path and inserts an 8-byte protection tuple into the metadata of every logical block that passes through it. Each logical block arrives as a run of data bytes followed by its metadata region. The block computes a 16-bit CRC guard over the block. It then replaces eight metadata bytes with the guard, a 16-bit application tag and a 32-bit reference tag. All other bytes leave exactly as they came in.

A transfer is opened with a one-cycle `start`. The configuration is captured at that start. It comprises the data size and metadata size, where the tuple sits, the protection type, the starting tags, the number of blocks and an optional check of the starting reference tag against the starting block address. A type 1 transfer that fails that check is refused before any byte moves. The stream path is a combinational pass-through. Backpressure from the consumer holds both the producer and the CRC. A `done` pulse marks the end of the last block.

Top module: `prot_tuple_gen`

## Requirements
- R1: The tuple is emitted most significant byte first, in this byte order: guard[15:8], guard[7:0], app[15:8], app[7:0], ref[31:24], ref[23:16], ref[15:8], ref[7:0].
- R2: The guard is a CRC with polynomial 0x8BB7. Bytes enter most significant bit first, with no reflection and no final XOR. The CRC is reset to 0 at the start of every logical block. The nine ASCII bytes "123456789" yield 0xD0DB.
- R3: With `cfg_tuple_head`=1, the tuple replaces metadata bytes 0 to 7, and only the data bytes feed the guard.
- R4: With `cfg_tuple_head`=0, the tuple replaces the last eight metadata bytes. The guard covers the data bytes and then the metadata bytes in front of the tuple.
- R5: Every byte outside the tuple leaves unchanged. The input bytes at tuple positions are consumed and discarded.
- R6: Every block of a transfer carries the same application tag, `cfg_app_tag`.
- R7: The reference tag starts at `cfg_ref_tag`. It increments by one (modulo 2^32) after each block when `cfg_prot_type` is 2'd1 or 2'd2. It stays constant when `cfg_prot_type` is 2'd3.
- R8: A start is refused when three conditions hold: `cfg_prot_type`=2'd1, `cfg_ref_check`=1, and `cfg_ref_tag`≠`cfg_base_lba`. A refused start raises `err` for one cycle, in the cycle after the start, and accepts and emits no byte. Any other type, or a cleared check enable, never raises `err`.
- R9: When `out_ready` is low, `in_ready` is low as well. A stall loses no byte and does not change the CRC or the byte position.
- R10: `done` is a one-cycle pulse in the cycle after the handshake of the final byte of block `cfg_blk_count` (`cfg_blk_count` ≥ 1).
- R11: Out of reset, `in_ready`, `out_valid`, `done` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a transfer when idle |
| cfg_blk_bytes | input | SZ_W | Data bytes per logical block |
| cfg_meta_bytes | input | SZ_W | Metadata bytes per block (at least 8) |
| cfg_tuple_head | input | 1 | 1: tuple in first 8 metadata bytes, 0: in last 8 |
| cfg_prot_type | input | 2 | Protection type 1, 2 or 3 |
| cfg_app_tag | input | 16 | Application tag |
| cfg_ref_tag | input | 32 | Starting reference tag |
| cfg_ref_check | input | 1 | Enables the starting reference check |
| cfg_base_lba | input | 32 | Low 32 bits of the starting block address |
| cfg_blk_count | input | CNT_W | Blocks in the transfer |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 8 | Output byte |
| done | output | 1 | End-of-transfer pulse |
| err | output | 1 | Refused-start pulse |

## Verification
The bench uses the default widths, SZ_W=12 and CNT_W=16. These allow block and metadata sizes well beyond the 64-byte data and 24-byte metadata that the vectors use, so both tuple placements can be exercised. The exercised cases include a metadata region that is exactly eight bytes, where no metadata byte feeds the guard, and a reference tag that wraps past 0xFFFFFFFF. The bench also drives stall patterns on both sides of the stream and includes a single-block known-answer case for the CRC.

// File: rtl/prot_tuple_gen.sv
module prot_tuple_gen #(
  parameter int          SZ_W  = 12,
  parameter int          CNT_W = 16,
  parameter logic [15:0] POLY  = 16'h8BB7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SZ_W-1:0]  cfg_blk_bytes,
  input  logic [SZ_W-1:0]  cfg_meta_bytes,
  input  logic             cfg_tuple_head,
  input  logic [1:0]       cfg_prot_type,
  input  logic [15:0]      cfg_app_tag,
  input  logic [31:0]      cfg_ref_tag,
  input  logic             cfg_ref_check,
  input  logic [31:0]      cfg_base_lba,
  input  logic [CNT_W-1:0] cfg_blk_count,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             done,
  output logic             err
);
  localparam int POS_W = SZ_W + 1;

  logic             busy_q, head_q, done_q, err_q;
  logic [SZ_W-1:0]  blk_q, meta_q;
  logic [1:0]       type_q;
  logic [15:0]      app_q, crc_q;
  logic [31:0]      ref_q;
  logic [CNT_W-1:0] left_q;
  logic [POS_W-1:0] pos_q;

  logic [POS_W-1:0] blk_w, meta_w, last_pos, tup_start, toff;
  logic             in_tuple, xfer, refuse;
  logic [63:0]      tuple;
  logic [7:0]       tbyte;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  assign blk_w     = POS_W'(blk_q);
  assign meta_w    = POS_W'(meta_q);
  assign last_pos  = blk_w + meta_w - POS_W'(1);
  assign tup_start = head_q ? blk_w : blk_w + meta_w - POS_W'(8);
  assign in_tuple  = (pos_q >= tup_start) && (pos_q < tup_start + POS_W'(8));
  assign toff      = pos_q - tup_start;
  assign tuple     = {crc_q, app_q, ref_q};
  assign tbyte     = 8'(tuple >> (6'd56 - {toff[2:0], 3'b000}));

  assign in_ready  = busy_q & out_ready;
  assign out_valid = busy_q & in_valid;
  assign out_data  = in_tuple ? tbyte : in_data;
  assign xfer      = in_valid & in_ready;
  assign done      = done_q;
  assign err       = err_q;
  assign refuse    = (cfg_prot_type == 2'd1) && cfg_ref_check && (cfg_ref_tag != cfg_base_lba);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      head_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      blk_q  <= '0;
      meta_q <= '0;
      type_q <= 2'd1;
      app_q  <= '0;
      crc_q  <= '0;
      ref_q  <= '0;
      left_q <= '0;
      pos_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          if (refuse) begin
            err_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            blk_q  <= cfg_blk_bytes;
            meta_q <= cfg_meta_bytes;
            head_q <= cfg_tuple_head;
            type_q <= cfg_prot_type;
            app_q  <= cfg_app_tag;
            ref_q  <= cfg_ref_tag;
            left_q <= cfg_blk_count;
            pos_q  <= '0;
            crc_q  <= '0;
          end
        end
      end else if (xfer) begin
        if (pos_q == last_pos) begin
          pos_q  <= '0;
          crc_q  <= '0;
          left_q <= left_q - CNT_W'(1);
          if (type_q != 2'd3) ref_q <= ref_q + 32'd1;
          if (left_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          pos_q <= pos_q + POS_W'(1);
          if (pos_q < tup_start) crc_q <= crc_step(crc_q, in_data);
        end
      end
    end
  end
endmodule

module prot_tuple_gen_chk #(
  parameter int SZ_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [1:0]      cfg_prot_type,
  input logic            cfg_ref_check,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            done,
  input logic            err,
  input logic            busy_q,
  input logic [1:0]      type_q,
  input logic [15:0]     crc_q,
  input logic [31:0]     ref_q,
  input logic [SZ_W:0]   pos_q
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !(in_valid && in_ready)) |=> ($stable(crc_q) && $stable(pos_q))); // R9
  AST_SEED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && pos_q == '0) |-> (crc_q == 16'h0000)); // R2
  AST_TYPE3_REF: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && type_q == 2'd3) |=> $stable(ref_q)); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) err |-> $past(start && !busy_q && cfg_prot_type == 2'd1 && cfg_ref_check)); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err |-> (!busy_q && !out_valid)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
endmodule

bind prot_tuple_gen prot_tuple_gen_chk #(.SZ_W(SZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_prot_type(cfg_prot_type),
  .cfg_ref_check(cfg_ref_check), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .done(done), .err(err), .busy_q(busy_q),
  .type_q(type_q), .crc_q(crc_q), .ref_q(ref_q), .pos_q(pos_q)
);

// File: tb/test_prot_tuple_gen.sv
module test_prot_tuple_gen;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [11:0] cfg_blk_bytes = '0, cfg_meta_bytes = '0;
  logic cfg_tuple_head = 1'b0, cfg_ref_check = 1'b0;
  logic [1:0] cfg_prot_type = 2'd1;
  logic [15:0] cfg_app_tag = '0, cfg_blk_count = '0;
  logic [31:0] cfg_ref_tag = '0, cfg_base_lba = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, done, err;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  prot_tuple_gen i_prot_tuple_gen (.*);

  int checks = 0, fails = 0;

  typedef struct packed {
    logic [11:0] blk; logic [11:0] meta; logic head; logic [1:0] typ;
    logic [15:0] app; logic [31:0] rf; logic chk; logic [31:0] lba;
    logic [7:0] n; logic bp; logic kat;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{12'd16, 12'd8,  1'b1, 2'd1, 16'h1234, 32'd100,      1'b1, 32'd100, 8'd3, 1'b0, 1'b0},
    '{12'd32, 12'd16, 1'b0, 2'd2, 16'hBEEF, 32'hFFFFFFFE, 1'b1, 32'd0,   8'd4, 1'b1, 1'b0},
    '{12'd20, 12'd12, 1'b1, 2'd3, 16'h0F0F, 32'h55AA55AA, 1'b1, 32'd0,   8'd3, 1'b1, 1'b0},
    '{12'd8,  12'd8,  1'b0, 2'd1, 16'h0001, 32'd7,        1'b0, 32'd9,   8'd2, 1'b0, 1'b0},
    '{12'd64, 12'd24, 1'b0, 2'd3, 16'hA5A5, 32'd1,        1'b0, 32'd0,   8'd2, 1'b1, 1'b0},
    '{12'd9,  12'd8,  1'b1, 2'd1, 16'h0000, 32'd0,        1'b1, 32'd0,   8'd1, 1'b0, 1'b1}
  };

  logic [15:0] ctab [256];
  logic [7:0] din [512];
  logic [7:0] dexp [512];
  logic [7:0] dgot [512];

  task automatic check(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int seed);
    int bsz, total, ts, cyc, idx;
    logic [15:0] crc;
    logic [31:0] rf;
    logic [63:0] tup, got;
    bit pass_ok;
    bsz = int'(v.blk) + int'(v.meta);
    total = int'(v.n) * bsz;
    for (int i = 0; i < total; i++) begin
      din[i] = v.kat && (i % bsz) < 9 ? 8'(8'h31 + i % bsz) : 8'((i * 7 + (i / bsz) * 31 + seed * 13) & 8'hFF);
      dexp[i] = din[i];
    end
    ts = v.head ? int'(v.blk) : bsz - 8;
    for (int b = 0; b < int'(v.n); b++) begin
      crc = 16'h0000;
      for (int p = 0; p < ts; p++) crc = (crc << 8) ^ ctab[(crc[15:8] ^ din[b * bsz + p])];
      rf = (v.typ == 2'd3) ? v.rf : v.rf + 32'(b);
      tup = {crc, v.app, rf};
      for (int k = 0; k < 8; k++) dexp[b * bsz + ts + k] = tup[63 - 8 * k -: 8];
    end
    @(negedge clk);
    cfg_blk_bytes = v.blk; cfg_meta_bytes = v.meta; cfg_tuple_head = v.head;
    cfg_prot_type = v.typ; cfg_app_tag = v.app; cfg_ref_tag = v.rf;
    cfg_ref_check = v.chk; cfg_base_lba = v.lba; cfg_blk_count = 16'(v.n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 check(err == 1'b0, "R8", "accepted start raised err", 64'(err), 64'd0);
    idx = 0; cyc = 0;
    while (idx < total) begin
      @(negedge clk);
      in_valid  = v.bp ? (cyc % 3 != 1) : 1'b1;
      out_ready = v.bp ? (cyc % 4 != 2) : 1'b1;
      in_data   = din[idx];
      #1;
      if (!out_ready && in_ready) check(1'b0, "R9", "in_ready while out_ready low", 64'(in_ready), 64'd0);
      if (in_valid && in_ready) begin
        dgot[idx] = out_data;
        idx++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1 check(done == 1'b1, "R10", "done after last byte", 64'(done), 64'd1);
    @(negedge clk);
    #1 check(done == 1'b0 && in_ready == 1'b0, "R10", "done one cycle then idle", {62'd0, done, in_ready}, 64'd0);
    for (int b = 0; b < int'(v.n); b++) begin
      got = '0; tup = '0;
      for (int k = 0; k < 8; k++) begin
        got = {got[55:0], dgot[b * bsz + ts + k]};
        tup = {tup[55:0], dexp[b * bsz + ts + k]};
      end
      check(got == tup, v.head ? "R1 R3 R6 R7" : "R1 R4 R6 R7", "tuple", got, tup);
      pass_ok = 1'b1;
      for (int p = 0; p < bsz; p++)
        if (dgot[b * bsz + p] != dexp[b * bsz + p] && (p < ts || p >= ts + 8)) pass_ok = 1'b0;
      check(pass_ok, v.bp ? "R5 R9" : "R5", "pass-through bytes", 64'(pass_ok), 64'd1);
    end
    if (v.kat) check(got[63:48] == 16'hD0DB, "R2", "known-answer guard", 64'(got[63:48]), 64'hD0DB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [15:0] r;
      r = 16'(x) << 8;
      for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h8BB7) : (r << 1);
      ctab[x] = r;
    end
    repeat (3) @(negedge clk);
    #1 check({in_ready, out_valid, done, err} == 4'b0000, "R11", "reset outputs", 64'({in_ready, out_valid, done, err}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b1;
    #1 check(in_ready == 1'b0 && out_valid == 1'b0, "R11", "idle after reset", {62'd0, in_ready, out_valid}, 64'd0);
    in_valid = 1'b0;
    for (int t = 0; t < 6; t++) run_vec(VEC[t], t);
    @(negedge clk);
    cfg_prot_type = 2'd1; cfg_ref_check = 1'b1; cfg_ref_tag = 32'd5; cfg_base_lba = 32'd6;
    cfg_blk_count = 16'd1; start = 1'b1; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1 check(err == 1'b1 && in_ready == 1'b0 && out_valid == 1'b0, "R8", "refused start",
             {61'd0, err, in_ready, out_valid}, 64'd4);
    @(negedge clk);
    #1 check(err == 1'b0 && in_ready == 1'b0, "R8", "err one cycle, nothing accepted", {62'd0, err, in_ready}, 64'd0);
    in_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule